// File: doc/BRIEF.md
# Transmit Page Quota Allocator

This block keeps the free-page accounts of a paged transmit buffer. The buffer holds 256 pages of 128 bytes (32 KiB) and is shared by four priority queues: high, normal, low and extra. A programmable boundary page splits the buffer. Pages below the boundary form the head region for host traffic. Pages at and above it form a tail region that is held for special frames such as beacons and null-data frames. This block never allocates tail pages.

Software gives each queue a reserved page count and also sets the size of a shared public pool. A load strobe copies these values into the live free counters. A requester names a queue and a page count. In the same cycle the block grants the request, taking pages from the queue's own reservation first and then from the public pool, or it refuses the request. A refusal leaves every counter unchanged and sets a sticky overflow flag.

For each queue the block keeps a count of pages borrowed from the public pool that are still outstanding. When pages are released, they go back to the public pool first, up to that borrowed count, and the rest go back to the queue. If the loaded reservations add up to more than the boundary, the block flags a configuration error and refuses every allocation.

Top module: `txq_page_alloc`

## Requirements
- R1: After reset, all four queue free counts and the public free count are zero, the overflow flag is low and the configuration error is low. The boundary resets to 255.
- R2: Configuration word B is staged when written. It holds the normal count in bits 7:0 and the extra count in bits 23:16. Configuration word A holds the high count in bits 7:0, the low count in bits 15:8 and the public count in bits 16 to 23. When word A is written with bit 31 set, the next cycle shows every reservation, including the staged word B values, as the free counts, and all borrowed counts are cleared. A word A write with bit 31 clear has no effect.
- R3: A request names a queue (0 high, 1 normal, 2 low, 3 extra) and n pages. It is granted in the same cycle when n ≥ 1, n ≤ the queue's free count plus the public free count, the configuration is valid and no load occurs in that cycle. The grant takes min(n, the queue's free count) from the queue and the remainder from the public pool.
- R4: A refused request raises the deny output in the same cycle and leaves all free counts unchanged.
- R5: The overflow flag is set on the cycle after any deny and stays set until the clear input is pulsed. If a deny and a clear occur in the same cycle, the set wins.
- R6: A release of n pages for queue q returns min(n, pages q has borrowed) to the public pool. It returns the remainder to q, limited to the pages q has in use (its reservation minus its free count). Any excess is dropped.
- R7: When the sum of the five loaded reservations is greater than the boundary, the configuration error is high and every request is denied.
- R8: A request made in the same cycle as a load is neither granted nor denied. A release in that cycle is ignored.
- R9: A request for zero pages is denied.
- R10: A request and a release in the same cycle are both applied, and both are evaluated against the counts held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_a_wr | input | 1 | Write strobe for configuration word A |
| cfg_a_word | input | 32 | High, low and public counts, with the load strobe in bit 31 |
| cfg_b_wr | input | 1 | Write strobe for configuration word B (staged) |
| cfg_b_word | input | 32 | Normal count in bits 7:0, extra count in bits 23:16 |
| bnd_wr | input | 1 | Boundary write strobe |
| bnd_page | input | 8 | Boundary page index, which equals the head region size in pages |
| alloc_valid | input | 1 | Allocation request |
| alloc_queue | input | 2 | Requesting queue |
| alloc_pages | input | 8 | Pages requested |
| alloc_grant | output | 1 | Request granted this cycle |
| alloc_deny | output | 1 | Request refused this cycle |
| rel_valid | input | 1 | Release request |
| rel_queue | input | 2 | Releasing queue |
| rel_pages | input | 8 | Pages released |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| cfg_err | output | 1 | Reservation sum is greater than the boundary |
| q_free_flat | output | 32 | Free counts packed as [8*q +: 8] |
| pub_free | output | 8 | Public pool free count |

## Verification
The main function is tested with three kinds of request. Requests that fit inside the queue's own reservation show that the public pool is left untouched. Requests that cross into the public pool show the split between own pages and borrowed pages. Requests one page too large show the refusal path and the sticky flag. Releases are tested below, at and above the borrowed count to check the return order and the clipping. Further tests cover a same-cycle allocation and release, a boundary moved just below and then onto the reservation sum, and a long random mix including reloads, each compared every cycle with a behavioural model.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int CNT_W  = 8;
  localparam int NUM_Q  = 4;
  localparam int Q_W    = 2;

  typedef enum logic [Q_W-1:0] {
    Q_HIGH  = 2'd0,
    Q_NORM  = 2'd1,
    Q_LOW   = 2'd2,
    Q_EXTRA = 2'd3
  } qsel_e;

  // field positions decoded from the two configuration words
  localparam int A_HIGH_LSB  = 0;
  localparam int A_LOW_LSB   = 8;
  localparam int A_PUB_LSB   = 16;
  localparam int A_LOAD_BIT  = 31;
  localparam int B_NORM_LSB  = 0;
  localparam int B_EXTRA_LSB = 16;
endpackage

// File: rtl/txq_cfg_regs.sv
module txq_cfg_regs #(
  parameter int CW      = txq_pkg::CNT_W,
  parameter int PGW     = 8,
  parameter int BND_RST = 255
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          a_wr,
  input  logic [31:0]                   a_word,
  input  logic                          b_wr,
  input  logic [31:0]                   b_word,
  input  logic                          bnd_wr,
  input  logic [PGW-1:0]                bnd_in,
  output logic                          load_o,
  output logic [txq_pkg::NUM_Q*CW-1:0]  load_q_o,
  output logic [CW-1:0]                 load_pub_o,
  output logic [txq_pkg::NUM_Q*CW-1:0]  resv_q_o,
  output logic [CW-1:0]                 resv_pub_o,
  output logic                          cfg_err_o
);
  import txq_pkg::*;
  localparam int SUM_W = CW + 3;

  logic [CW-1:0]        stg_norm_q, stg_extra_q;
  logic [CW-1:0]        stg_norm_d, stg_extra_d;
  logic [PGW-1:0]       bnd_q, bnd_d;
  logic [NUM_Q*CW-1:0]  resv_q, resv_d;
  logic [CW-1:0]        rpub_q, rpub_d;
  logic [SUM_W-1:0]     sum;
  logic                 unused_cfg_bits;

  assign unused_cfg_bits = ^{a_word[30:A_PUB_LSB+CW], b_word[31:B_EXTRA_LSB+CW],
                             b_word[B_EXTRA_LSB-1:B_NORM_LSB+CW]};

  assign load_o = a_wr && a_word[A_LOAD_BIT];

  always_comb begin
    load_q_o = '0;
    load_q_o[Q_HIGH*CW  +: CW] = a_word[A_HIGH_LSB +: CW];
    load_q_o[Q_NORM*CW  +: CW] = stg_norm_q;
    load_q_o[Q_LOW*CW   +: CW] = a_word[A_LOW_LSB +: CW];
    load_q_o[Q_EXTRA*CW +: CW] = stg_extra_q;
    load_pub_o = a_word[A_PUB_LSB +: CW];
  end

  always_comb begin
    stg_norm_d  = b_wr   ? b_word[B_NORM_LSB +: CW]  : stg_norm_q;
    stg_extra_d = b_wr   ? b_word[B_EXTRA_LSB +: CW] : stg_extra_q;
    bnd_d       = bnd_wr ? bnd_in                    : bnd_q;
    resv_d      = load_o ? load_q_o                  : resv_q;
    rpub_d      = load_o ? load_pub_o                : rpub_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_norm_q  <= '0;
      stg_extra_q <= '0;
      bnd_q       <= PGW'(BND_RST);
      resv_q      <= '0;
      rpub_q      <= '0;
    end else begin
      stg_norm_q  <= stg_norm_d;
      stg_extra_q <= stg_extra_d;
      bnd_q       <= bnd_d;
      resv_q      <= resv_d;
      rpub_q      <= rpub_d;
    end
  end

  always_comb begin
    sum = SUM_W'(rpub_q);
    for (int i = 0; i < NUM_Q; i++) begin
      sum = sum + SUM_W'(resv_q[i*CW +: CW]);
    end
  end

  assign cfg_err_o  = sum > SUM_W'(bnd_q);
  assign resv_q_o   = resv_q;
  assign resv_pub_o = rpub_q;
endmodule

// File: rtl/txq_alloc_decide.sv
module txq_alloc_decide #(
  parameter int CW = txq_pkg::CNT_W
) (
  input  logic [txq_pkg::NUM_Q*CW-1:0]  free_flat,
  input  logic [txq_pkg::NUM_Q*CW-1:0]  borrow_flat,
  input  logic [txq_pkg::NUM_Q*CW-1:0]  resv_flat,
  input  logic [CW-1:0]                 pub_free,
  input  logic                          block_all,
  input  logic                          cfg_err,
  input  logic                          req_valid,
  input  logic [txq_pkg::Q_W-1:0]       req_q,
  input  logic [CW-1:0]                 req_n,
  input  logic [txq_pkg::Q_W-1:0]       rel_q,
  input  logic [CW-1:0]                 rel_n,
  output logic                          grant,
  output logic                          deny,
  output logic [CW-1:0]                 take_own,
  output logic [CW-1:0]                 take_pub,
  output logic [CW-1:0]                 back_own,
  output logic [CW-1:0]                 back_pub
);
  logic [CW-1:0] sel_free, r_bor, r_used, r_rest;
  logic [CW:0]   avail;
  logic          fits;

  always_comb begin
    sel_free = free_flat[req_q*CW +: CW];
    avail    = {1'b0, sel_free} + {1'b0, pub_free};
    fits     = (req_n != '0) && ({1'b0, req_n} <= avail);
    grant    = req_valid && !block_all && !cfg_err && fits;
    deny     = req_valid && !block_all && !grant;
    take_own = (req_n <= sel_free) ? req_n : sel_free;
    take_pub = req_n - take_own;
  end

  always_comb begin
    r_bor    = borrow_flat[rel_q*CW +: CW];
    r_used   = resv_flat[rel_q*CW +: CW] - free_flat[rel_q*CW +: CW];
    back_pub = (rel_n <= r_bor) ? rel_n : r_bor;
    r_rest   = rel_n - back_pub;
    back_own = (r_rest <= r_used) ? r_rest : r_used;
  end
endmodule

// File: rtl/txq_queue_ctr.sv
module txq_queue_ctr #(
  parameter int CW = txq_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          take_en,
  input  logic [CW-1:0] take_own,
  input  logic [CW-1:0] take_pub,
  input  logic          ret_en,
  input  logic [CW-1:0] ret_own,
  input  logic [CW-1:0] ret_pub,
  output logic [CW-1:0] free_o,
  output logic [CW-1:0] borrow_o
);
  logic [CW-1:0] free_q, free_d, bor_q, bor_d;
  logic          upd_en;

  assign upd_en = load || take_en || ret_en;

  always_comb begin
    if (load) begin
      free_d = load_val;
      bor_d  = '0;
    end else begin
      free_d = free_q - (take_en ? take_own : '0) + (ret_en ? ret_own : '0);
      bor_d  = bor_q  + (take_en ? take_pub : '0) - (ret_en ? ret_pub : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= '0;
      bor_q  <= '0;
    end else if (upd_en) begin
      free_q <= free_d;
      bor_q  <= bor_d;
    end
  end

  assign free_o   = free_q;
  assign borrow_o = bor_q;
endmodule

// File: rtl/txq_page_alloc.sv
module txq_page_alloc #(
  parameter int CNT_W     = txq_pkg::CNT_W,
  parameter int NUM_PAGES = 256,
  parameter int PG_W      = $clog2(NUM_PAGES),
  parameter int BND_RST   = NUM_PAGES - 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_a_wr,
  input  logic [31:0]                        cfg_a_word,
  input  logic                               cfg_b_wr,
  input  logic [31:0]                        cfg_b_word,
  input  logic                               bnd_wr,
  input  logic [PG_W-1:0]                    bnd_page,
  input  logic                               alloc_valid,
  input  logic [txq_pkg::Q_W-1:0]            alloc_queue,
  input  logic [CNT_W-1:0]                   alloc_pages,
  output logic                               alloc_grant,
  output logic                               alloc_deny,
  input  logic                               rel_valid,
  input  logic [txq_pkg::Q_W-1:0]            rel_queue,
  input  logic [CNT_W-1:0]                   rel_pages,
  input  logic                               ovf_clr,
  output logic                               ovf_flag,
  output logic                               cfg_err,
  output logic [txq_pkg::NUM_Q*CNT_W-1:0]    q_free_flat,
  output logic [CNT_W-1:0]                   pub_free
);
  import txq_pkg::*;

  logic                     rst_s1_n, rst_q_n;
  logic                     load;
  logic [NUM_Q*CNT_W-1:0]   load_q, resv_q, bor_flat;
  logic [CNT_W-1:0]         load_pub, resv_pub;
  logic [CNT_W-1:0]         take_own, take_pub, back_own, back_pub;
  logic                     rel_ok;
  logic [CNT_W-1:0]         pub_q, pub_d;
  logic                     ovf_q, ovf_d;
  logic                     unused_resv_pub;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_q_n  <= rst_s1_n;
    end
  end

  txq_cfg_regs #(.CW(CNT_W), .PGW(PG_W), .BND_RST(BND_RST)) cfg_i (
    .clk(clk), .rst_n(rst_q_n),
    .a_wr(cfg_a_wr), .a_word(cfg_a_word),
    .b_wr(cfg_b_wr), .b_word(cfg_b_word),
    .bnd_wr(bnd_wr), .bnd_in(bnd_page),
    .load_o(load), .load_q_o(load_q), .load_pub_o(load_pub),
    .resv_q_o(resv_q), .resv_pub_o(resv_pub), .cfg_err_o(cfg_err)
  );

  assign unused_resv_pub = ^resv_pub;

  txq_alloc_decide #(.CW(CNT_W)) dec_i (
    .free_flat(q_free_flat), .borrow_flat(bor_flat), .resv_flat(resv_q),
    .pub_free(pub_q), .block_all(load), .cfg_err(cfg_err),
    .req_valid(alloc_valid), .req_q(alloc_queue), .req_n(alloc_pages),
    .rel_q(rel_queue), .rel_n(rel_pages),
    .grant(alloc_grant), .deny(alloc_deny),
    .take_own(take_own), .take_pub(take_pub),
    .back_own(back_own), .back_pub(back_pub)
  );

  assign rel_ok = rel_valid && !load;

  for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
    txq_queue_ctr #(.CW(CNT_W)) ctr_i (
      .clk(clk), .rst_n(rst_q_n),
      .load(load), .load_val(load_q[g*CNT_W +: CNT_W]),
      .take_en(alloc_grant && (alloc_queue == Q_W'(g))),
      .take_own(take_own), .take_pub(take_pub),
      .ret_en(rel_ok && (rel_queue == Q_W'(g))),
      .ret_own(back_own), .ret_pub(back_pub),
      .free_o(q_free_flat[g*CNT_W +: CNT_W]),
      .borrow_o(bor_flat[g*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    if (load) pub_d = load_pub;
    else      pub_d = pub_q - (alloc_grant ? take_pub : '0) + (rel_ok ? back_pub : '0);
    if (alloc_deny)   ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
    else              ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pub_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (load || alloc_grant || rel_ok) pub_q <= pub_d;
      ovf_q <= ovf_d;
    end
  end

  assign pub_free = pub_q;
  assign ovf_flag = ovf_q;
endmodule

// File: rtl/txq_page_alloc_chk.sv
module txq_page_alloc_chk #(
  parameter int CW = 8,
  parameter int NQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_a_wr,
  input logic [31:0]     cfg_a_word,
  input logic            alloc_grant,
  input logic            alloc_deny,
  input logic            rel_valid,
  input logic            ovf_clr,
  input logic            ovf_flag,
  input logic            cfg_err,
  input logic [NQ*CW-1:0] q_free_flat,
  input logic [CW-1:0]   pub_free
);
  logic load_seen;
  assign load_seen = cfg_a_wr && cfg_a_word[31];

  p_one_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_grant && alloc_deny));

  p_grant_no_pub_gain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant && !rel_valid |=> pub_free <= $past(pub_free));

  p_deny_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_deny && !rel_valid |=> $stable(q_free_flat) && $stable(pub_free));

  p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_deny |=> ovf_flag);

  p_ovf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag);

  p_err_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !alloc_grant);

  p_load_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_seen |-> !alloc_grant && !alloc_deny);

  p_load_pub_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_seen |=> pub_free == $past(cfg_a_word[23:16]));
endmodule

bind txq_page_alloc txq_page_alloc_chk #(.CW(CNT_W), .NQ(txq_pkg::NUM_Q)) chk_i (
  .clk(clk), .rst_n(rst_q_n), .cfg_a_wr(cfg_a_wr), .cfg_a_word(cfg_a_word),
  .alloc_grant(alloc_grant), .alloc_deny(alloc_deny), .rel_valid(rel_valid),
  .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .cfg_err(cfg_err),
  .q_free_flat(q_free_flat), .pub_free(pub_free)
);

// File: tb/txq_page_alloc_tb.sv
module txq_page_alloc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_a_wr = 0, cfg_b_wr = 0, bnd_wr = 0;
  logic [31:0] cfg_a_word = 0, cfg_b_word = 0;
  logic [7:0]  bnd_page = 0;
  logic        alloc_valid = 0, rel_valid = 0, ovf_clr = 0;
  logic [1:0]  alloc_queue = 0, rel_queue = 0;
  logic [7:0]  alloc_pages = 0, rel_pages = 0;
  logic        alloc_grant, alloc_deny, ovf_flag, cfg_err;
  logic [31:0] q_free_flat;
  logic [7:0]  pub_free;

  int total = 0, bad = 0;
  int m_free[4], m_bor[4], m_resv[4];
  int m_pub = 0, m_rpub = 0, m_ovf = 0, m_sn = 0, m_se = 0, m_bnd = 255;

  always #5 clk = ~clk;

  txq_page_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_a_wr(cfg_a_wr), .cfg_a_word(cfg_a_word),
    .cfg_b_wr(cfg_b_wr), .cfg_b_word(cfg_b_word), .bnd_wr(bnd_wr), .bnd_page(bnd_page),
    .alloc_valid(alloc_valid), .alloc_queue(alloc_queue), .alloc_pages(alloc_pages),
    .alloc_grant(alloc_grant), .alloc_deny(alloc_deny),
    .rel_valid(rel_valid), .rel_queue(rel_queue), .rel_pages(rel_pages),
    .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .cfg_err(cfg_err),
    .q_free_flat(q_free_flat), .pub_free(pub_free)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int qf(int q);
    return int'(q_free_flat[q*8 +: 8]);
  endfunction

  function automatic int mn(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // one clock: compare with the model, then advance the model
  task automatic tick(string tag);
    int q, n, f, own, rq, rn, bp, bo, sum;
    bit ld, g, d, err;
    #1;
    for (int i = 0; i < 4; i++) chk(qf(i) == m_free[i], tag, "queue free", qf(i), m_free[i]);
    chk(int'(pub_free) == m_pub, tag, "public free", pub_free, m_pub);
    chk(int'(ovf_flag) == m_ovf, tag, "overflow", ovf_flag, m_ovf);
    sum = m_rpub;
    for (int i = 0; i < 4; i++) sum += m_resv[i];
    err = sum > m_bnd;
    chk(cfg_err == err, tag, "cfg error", cfg_err, err);
    ld = cfg_a_wr && cfg_a_word[31];
    g = 0; d = 0; q = alloc_queue; n = alloc_pages; f = m_free[q];
    if (!ld && alloc_valid) begin
      g = (n >= 1) && (n <= f + m_pub) && !err;
      d = !g;
    end
    chk(alloc_grant == g, tag, "grant", alloc_grant, g);
    chk(alloc_deny == d, tag, "deny", alloc_deny, d);
    if (ld) begin
      m_resv[0] = cfg_a_word[7:0];  m_resv[1] = m_sn;
      m_resv[2] = cfg_a_word[15:8]; m_resv[3] = m_se;
      m_rpub = cfg_a_word[23:16];
      for (int i = 0; i < 4; i++) begin m_free[i] = m_resv[i]; m_bor[i] = 0; end
      m_pub = m_rpub;
    end else begin
      rq = rel_queue; rn = rel_pages;
      bp = mn(rn, m_bor[rq]);
      bo = mn(rn - bp, m_resv[rq] - m_free[rq]);
      if (g) begin
        own = mn(n, f);
        m_free[q] -= own; m_pub -= n - own; m_bor[q] += n - own;
      end
      if (rel_valid) begin
        m_free[rq] += bo; m_pub += bp; m_bor[rq] -= bp;
      end
    end
    if (d) m_ovf = 1;
    else if (ovf_clr) m_ovf = 0;
    if (cfg_b_wr) begin m_sn = cfg_b_word[7:0]; m_se = cfg_b_word[23:16]; end
    if (bnd_wr) m_bnd = bnd_page;
    @(posedge clk);
    @(negedge clk);
    cfg_a_wr = 0; cfg_b_wr = 0; bnd_wr = 0;
    alloc_valid = 0; rel_valid = 0; ovf_clr = 0;
  endtask

  task automatic req(int q, int n);
    alloc_valid = 1; alloc_queue = 2'(q); alloc_pages = 8'(n);
  endtask

  task automatic rel(int q, int n);
    rel_valid = 1; rel_queue = 2'(q); rel_pages = 8'(n);
  endtask

  task automatic load(int hi, int lo, int pb);
    cfg_a_wr = 1; cfg_a_word = {1'b1, 7'd0, 8'(pb), 8'(lo), 8'(hi)};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_free[i] = 0; m_bor[i] = 0; m_resv[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    tick("R1");                                   // reset state
    req(0, 1); tick("R4");                        // nothing loaded: refused
    chk(ovf_flag == 1, "R5", "ovf after deny", ovf_flag, 1);
    tick("R5");                                   // stays set
    ovf_clr = 1; tick("R5");
    chk(ovf_flag == 0, "R5", "ovf cleared", ovf_flag, 0);

    cfg_b_wr = 1; cfg_b_word = {8'd0, 8'd2, 8'd0, 8'd3}; tick("R2");
    load(4, 5, 6); req(0, 1); tick("R8");         // load cycle: request ignored
    chk(qf(0) == 4 && qf(1) == 3 && qf(2) == 5 && qf(3) == 2, "R2", "loaded queues",
        qf(0) + qf(1) + qf(2) + qf(3), 14);
    chk(pub_free == 6, "R2", "loaded public", pub_free, 6);
    cfg_a_wr = 1; cfg_a_word = 32'h0009_0909; tick("R2");   // no strobe: no effect
    chk(qf(0) == 4, "R2", "unstrobed word", qf(0), 4);

    req(0, 3); tick("R3");
    chk(qf(0) == 1 && pub_free == 6, "R3", "own pages only", qf(0), 1);
    req(0, 3); tick("R3");
    chk(qf(0) == 0 && pub_free == 4, "R3", "spill to public", pub_free, 4);
    req(2, 10); tick("R4");                       // 5 + 4 < 10
    chk(qf(2) == 5 && pub_free == 4, "R4", "refused unchanged", qf(2), 5);
    ovf_clr = 1; tick("R5");
    req(3, 0); tick("R9");
    ovf_clr = 1; alloc_valid = 0; tick("R5");
    ovf_clr = 1; req(3, 20); tick("R5");          // set beats clear
    chk(ovf_flag == 1, "R5", "set wins", ovf_flag, 1);

    rel(0, 3); tick("R6");                        // 2 to public, 1 to queue
    chk(qf(0) == 1 && pub_free == 6, "R6", "public first", pub_free, 6);
    req(1, 4); rel(0, 1); tick("R10");
    chk(qf(0) == 2 && qf(1) == 0 && pub_free == 5, "R10", "joint update", pub_free, 5);
    rel(0, 10); tick("R6");                       // clipped at in-use count
    chk(qf(0) == 4, "R6", "release clipped", qf(0), 4);

    bnd_wr = 1; bnd_page = 8'd19; tick("R7");     // sum 20 > 19
    chk(cfg_err == 1, "R7", "cfg error", cfg_err, 1);
    req(0, 1); tick("R7");
    bnd_wr = 1; bnd_page = 8'd20; tick("R7");
    chk(cfg_err == 0, "R7", "cfg error gone", cfg_err, 0);

    for (int k = 0; k < 600; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 4) begin
        cfg_b_wr = 1; cfg_b_word = {8'd0, 8'($urandom_range(0, 30)), 8'd0, 8'($urandom_range(0, 30))};
      end else if (r < 8) begin
        load($urandom_range(0, 30), $urandom_range(0, 30), $urandom_range(0, 40));
      end else if (r < 11) begin
        bnd_wr = 1; bnd_page = 8'($urandom_range(60, 255));
      end
      if ($urandom_range(0, 2) != 0) req($urandom_range(0, 3), $urandom_range(0, 12));
      if ($urandom_range(0, 2) == 0) rel($urandom_range(0, 3), $urandom_range(0, 12));
      if ($urandom_range(0, 9) == 0) ovf_clr = 1;
      tick("R3");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule